// File: doc/BRIEF.md
# Partitioned Packed Prefix Adder

This block is a purely combinational adder for a 32-bit datapath. It can work as one full-width adder, as two independent 16-bit adders or as four independent 8-bit adders. A two-bit mode input picks the split on every evaluation, so a media or vector unit can issue mixed packed and scalar additions through the same hardware with no reconfiguration delay.

The adder uses a single parallel prefix carry tree. Lanes are separated inside that tree, not by gates in series on a carry chain and not by padding the operands. At every active lane boundary, the bit-level "carry survives" term is cleared, so no carry can enter the upper lane. The carry into the lowest bit of the upper lane is also forced low.

The group generate that ends just below each boundary is left untouched. It becomes that lane's carry-out. Carry-outs are returned packed by lane index on a four-bit vector. A parameter chooses the tree shape: unit lateral fan-out with wide wiring, or doubling fan-out with fewer cells. Both shapes give identical results.

Top module: `packed_prefix_adder`

## Requirements
- R1: With mode 2'b00 the block returns `sum_o = (a_i + b_i) mod 2^32`. `cout_o[0]` is the carry out of bit 31, and `cout_o[3:1]` read 0.
- R2: With mode 2'b01, `sum_o[15:0]` and `sum_o[31:16]` are each the 16-bit sum of the matching operand halves, taken modulo 2^16.
- R3: With mode 2'b01, `cout_o[0]` is the carry out of the low half, `cout_o[1]` is the carry out of the high half, and `cout_o[3:2]` read 0.
- R4: With mode 2'b10, each byte `sum_o[8j+7:8j]` (j = 0..3) is the modulo-256 sum of operand byte j.
- R5: With mode 2'b10, `cout_o[j]` is the carry out of byte lane j.
- R6: Mode 2'b11 behaves exactly like mode 2'b10, in both the sums and the carry-outs.
- R7: No carry crosses an active lane boundary. Operands that would ripple through every bit (for example all-ones plus a one in each lane) wrap inside each lane and leave the other lanes unchanged.
- R8: Carries cross the boundaries that the chosen mode does not activate. For example, in mode 2'b01 the sum 0x000000FF + 0x00000001 is 0x00000100.
- R9: The unit-fan-out tree shape and the doubling-fan-out tree shape give identical `sum_o` and `cout_o` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| mode_i | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 or 11 four lanes |
| sum_o | output | 32 | Packed sum |
| cout_o | output | 4 | Carry-out per lane, indexed by lane number; unused bits read 0 |

## Verification
The embedded assertions re-check every evaluation against a plain arithmetic sum of each lane. They cover the full-width, half-width and byte-width sums and carry-outs, with mode 2'b11 following the byte-lane check. They also check that the number of active boundaries matches the mode.

Only the bench can show that the two tree shapes agree with each other. The bench also drives the specific patterns that show blocked ripple at active boundaries and free ripple across inactive ones, scoring each lane against an independent model.

// File: rtl/packadd_pkg.sv
package packadd_pkg;

   // Lane split selection carried on the mode input.
   typedef enum logic [1:0] {
      SPLIT_ONE  = 2'b00,
      SPLIT_TWO  = 2'b01,
      SPLIT_FOUR = 2'b10,
      SPLIT_FOUR_ALIAS = 2'b11
   } split_e;

   // Prefix tree shape selectors.
   localparam int SHAPE_UNIT_FANOUT   = 0;
   localparam int SHAPE_DOUBLE_FANOUT = 1;

   function automatic int clog2_int(input int value);
      int r;
      r = 0;
      while ((1 << r) < value) r++;
      return r;
   endfunction

endpackage

// File: rtl/packadd_cut.sv
module packadd_cut
   import packadd_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG   = 8,
   localparam int NSEG = WIDTH / SEG
) (
   input  logic [1:0]       mode_i,
   output logic [WIDTH-1:0] cut_o
);

   always_comb begin
      cut_o = '0;
      for (int s = 1; s < NSEG; s++) begin
         case (split_e'(mode_i))
            SPLIT_ONE: cut_o[s*SEG] = 1'b0;
            SPLIT_TWO: cut_o[s*SEG] = (s == NSEG/2);
            default:   cut_o[s*SEG] = 1'b1;
         endcase
      end
   end

   // R7
   always_comb begin
      case (split_e'(mode_i))
         SPLIT_ONE: lane_cut_count_chk: assert ($countones(cut_o) == 0);
         SPLIT_TWO: lane_cut_count_chk2: assert ($countones(cut_o) == 1);
         default:   lane_cut_count_chk4: assert ($countones(cut_o) == NSEG - 1);
      endcase
   end

endmodule

// File: rtl/packadd_tree.sv
module packadd_tree
   import packadd_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SHAPE = SHAPE_UNIT_FANOUT,
   localparam int LVL  = clog2_int(WIDTH)
) (
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] live_i,
   output logic [WIDTH-1:0] grp_gen_o
);

   logic [LVL:0][WIDTH-1:0] gt;
   logic [LVL:0][WIDTH-1:0] lt;

   assign gt[0] = gen_i;
   assign lt[0] = live_i;

   for (genvar l = 0; l < LVL; l++) begin : g_level
      localparam int D = 1 << l;
      for (genvar i = 0; i < WIDTH; i++) begin : g_node
         if (SHAPE == SHAPE_UNIT_FANOUT) begin : g_unit
            if (i >= D) begin : g_cell
               assign gt[l+1][i] = gt[l][i] | (lt[l][i] & gt[l][i-D]);
               assign lt[l+1][i] = lt[l][i] & lt[l][i-D];
            end else begin : g_pass
               assign gt[l+1][i] = gt[l][i];
               assign lt[l+1][i] = lt[l][i];
            end
         end else begin : g_double
            if (((i >> l) & 1) == 1) begin : g_cell
               localparam int J = ((i >> l) << l) - 1;
               assign gt[l+1][i] = gt[l][i] | (lt[l][i] & gt[l][J]);
               assign lt[l+1][i] = lt[l][i] & lt[l][J];
            end else begin : g_pass
               assign gt[l+1][i] = gt[l][i];
               assign lt[l+1][i] = lt[l][i];
            end
         end
      end
   end

   assign grp_gen_o = gt[LVL];

endmodule

// File: rtl/packadd_post.sv
module packadd_post
   import packadd_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG   = 8,
   localparam int NSEG = WIDTH / SEG,
   localparam int HALF = WIDTH / 2
) (
   input  logic [1:0]       mode_i,
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] cut_i,
   input  logic [WIDTH-1:0] grp_gen_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [NSEG-1:0]  cout_o
);

   logic [WIDTH-1:0] carry_in;

   always_comb begin
      carry_in[0] = 1'b0;
      for (int i = 1; i < WIDTH; i++)
         carry_in[i] = grp_gen_i[i-1] & ~cut_i[i];
   end

   assign sum_o = prop_i ^ carry_in;

   always_comb begin
      cout_o = '0;
      case (split_e'(mode_i))
         SPLIT_ONE: cout_o[0] = grp_gen_i[WIDTH-1];
         SPLIT_TWO: begin
            cout_o[0] = grp_gen_i[HALF-1];
            cout_o[1] = grp_gen_i[WIDTH-1];
         end
         default: begin
            for (int s = 0; s < NSEG; s++)
               cout_o[s] = grp_gen_i[(s+1)*SEG-1];
         end
      endcase
   end

endmodule

// File: rtl/packed_prefix_adder.sv
module packed_prefix_adder
   import packadd_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG   = 8,
   parameter int SHAPE = SHAPE_UNIT_FANOUT,
   localparam int NSEG = WIDTH / SEG,
   localparam int HALF = WIDTH / 2
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       mode_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [NSEG-1:0]  cout_o
);

   if (WIDTH % SEG != 0) begin : g_bad_seg
      $error("WIDTH must be a multiple of SEG");
   end
   if (NSEG < 2 || (NSEG & (NSEG - 1)) != 0) begin : g_bad_nseg
      $error("WIDTH/SEG must be a power of two of at least 2");
   end
   if (SHAPE != SHAPE_UNIT_FANOUT && SHAPE != SHAPE_DOUBLE_FANOUT) begin : g_bad_shape
      $error("SHAPE selects an unknown tree");
   end

   logic [WIDTH-1:0] cut;
   logic [WIDTH-1:0] gen_bit;
   logic [WIDTH-1:0] live_bit;
   logic [WIDTH-1:0] prop_bit;
   logic [WIDTH-1:0] grp_gen;

   packadd_cut #(.WIDTH(WIDTH), .SEG(SEG)) u_cut (
      .mode_i (mode_i),
      .cut_o  (cut)
   );

   assign gen_bit  = a_i & b_i;
   assign live_bit = (a_i | b_i) & ~cut;
   assign prop_bit = a_i ^ b_i;

   packadd_tree #(.WIDTH(WIDTH), .SHAPE(SHAPE)) u_tree (
      .gen_i     (gen_bit),
      .live_i    (live_bit),
      .grp_gen_o (grp_gen)
   );

   packadd_post #(.WIDTH(WIDTH), .SEG(SEG)) u_post (
      .mode_i    (mode_i),
      .prop_i    (prop_bit),
      .cut_i     (cut),
      .grp_gen_i (grp_gen),
      .sum_o     (sum_o),
      .cout_o    (cout_o)
   );

   always_comb begin
      case (split_e'(mode_i))
         SPLIT_ONE: begin
            // R1
            full_sum_chk: assert ({cout_o[0], sum_o} == ({1'b0, a_i} + {1'b0, b_i}));
            // R1
            full_spare_chk: assert (cout_o[NSEG-1:1] == '0);
         end
         SPLIT_TWO: begin
            for (int h = 0; h < 2; h++) begin
               // R2
               half_sum_chk: assert (sum_o[h*HALF +: HALF] ==
                  HALF'(a_i[h*HALF +: HALF] + b_i[h*HALF +: HALF]));
               // R3
               half_cout_chk: assert ({cout_o[h], sum_o[h*HALF +: HALF]} ==
                  ({1'b0, a_i[h*HALF +: HALF]} + {1'b0, b_i[h*HALF +: HALF]}));
            end
            // R3
            half_spare_chk: assert (cout_o[NSEG-1:2] == '0);
         end
         default: begin
            // R4 R5 R6 (mode 2'b11 shares this check)
            for (int s = 0; s < NSEG; s++) begin
               seg_lane_chk: assert ({cout_o[s], sum_o[s*SEG +: SEG]} ==
                  ({1'b0, a_i[s*SEG +: SEG]} + {1'b0, b_i[s*SEG +: SEG]}));
            end
         end
      endcase
   end

endmodule

// File: tb/packed_prefix_adder_tb.sv
module packed_prefix_adder_tb;

   typedef struct {
      logic [1:0]  mode;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] sum;
      logic [3:0]  cout;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a_s = '0;
   logic [31:0] b_s = '0;
   logic [1:0]  mode_s = '0;
   logic [31:0] sum_w, sum_alt;
   logic [3:0]  cout_w, cout_alt;

   item_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   packed_prefix_adder #(.WIDTH(32), .SEG(8), .SHAPE(0)) u_dut (
      .a_i(a_s), .b_i(b_s), .mode_i(mode_s), .sum_o(sum_w), .cout_o(cout_w)
   );

   packed_prefix_adder #(.WIDTH(32), .SEG(8), .SHAPE(1)) u_dut_alt (
      .a_i(a_s), .b_i(b_s), .mode_i(mode_s), .sum_o(sum_alt), .cout_o(cout_alt)
   );

   function automatic item_t model(logic [1:0] m, logic [31:0] a, logic [31:0] b, string tag);
      item_t it;
      int w;
      logic [63:0] mask, x, y, s;
      it.mode = m; it.a = a; it.b = b; it.tag = tag;
      it.sum = '0; it.cout = '0;
      w = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
      mask = (64'd1 << w) - 1;
      for (int l = 0; l < 32 / w; l++) begin
         x = ({32'd0, a} >> (l*w)) & mask;
         y = ({32'd0, b} >> (l*w)) & mask;
         s = x + y;
         it.sum = it.sum | 32'((s & mask) << (l*w));
         it.cout[l] = s[w];
      end
      return it;
   endfunction

   task automatic drive(logic [1:0] m, logic [31:0] a, logic [31:0] b, string tag);
      @(posedge clk);
      #1;
      mode_s = m; a_s = a; b_s = b;
      q.push_back(model(m, a, b, tag));
   endtask

   task automatic check32(string tag, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check32(it.tag, sum_w, it.sum, "sum");
         check32(it.tag, {28'd0, cout_w}, {28'd0, it.cout}, "cout");
         check32("R9", sum_alt, it.sum, "alt sum");
         check32("R9", {28'd0, cout_alt}, {28'd0, it.cout}, "alt cout");
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state after reset: zero inputs give zero outputs (R1)
      drive(2'b00, 32'h0, 32'h0, "R1");
      // R1 full width
      drive(2'b00, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
      drive(2'b00, 32'h8000_0000, 32'h8000_0000, "R1");
      drive(2'b00, 32'h1234_5678, 32'h8765_4321, "R1");
      // R8 inactive boundaries ripple
      drive(2'b00, 32'h0000_FFFF, 32'h0000_0001, "R8");
      drive(2'b01, 32'h0000_00FF, 32'h0000_0001, "R8");
      drive(2'b01, 32'h00FF_0000, 32'h0001_0000, "R8");
      // R2 R3 half lanes
      drive(2'b01, 32'hFFFF_FFFF, 32'h0001_0001, "R7");
      drive(2'b01, 32'hFFFF_0000, 32'h0001_0000, "R3");
      drive(2'b01, 32'h0000_FFFF, 32'h0000_0001, "R2");
      drive(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
      // R4 R5 byte lanes
      drive(2'b10, 32'hFFFF_FFFF, 32'h0101_0101, "R7");
      drive(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
      drive(2'b10, 32'h00FF_00FF, 32'h0001_0001, "R7");
      drive(2'b10, 32'h7F80_01FE, 32'h0180_FF02, "R4");
      // R6 alias mode
      drive(2'b11, 32'hFFFF_FFFF, 32'h0101_0101, "R6");
      drive(2'b11, 32'hA5A5_5A5A, 32'h5A5B_A5A6, "R6");
      for (int n = 0; n < 40; n++) begin
         drive(2'b00, $urandom, $urandom, "R1");
         drive(2'b01, $urandom, $urandom, "R2");
         drive(2'b10, $urandom, $urandom, "R4");
         drive(2'b11, $urandom, $urandom, "R6");
      end
      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule